// File: doc/BRIEF.md
# Tamper Detection and Key Zeroization Unit

This unit lives in the always-powered battery domain of a secure controller. It watches a set of external tamper pins and eight internal alarm conditions. Each source latches its own flag, and any enabled flag drives one sticky global tamper flag. When the global flag rises, the unit does three things in hardware, with no software step: it stores the current seconds count as the tamper time, it starts zero-write sweeps over the secure key store, the session RAM and, if configured, the battery-backed register file, and it hides key read data until the key sweep has finished.

Software sees the flags, clears them with write-one-to-clear strobes, and can force the full tamper response with a single strobe. The global flag is also raised by a power-on reset of the battery domain, and session RAM is swept again after every system reset. The unit has three optional outputs, each with its own enable: an interrupt level, a wakeup level and a one-cycle chip-reset request.

Top module: `tamper_guard`

## Requirements
- R1: Each tamper pin goes through a two-flop synchronizer and then a glitch filter. Its pin flag sets only after the synchronized pin has been high for `cfg_filt_len` consecutive cycles, where a length of 0 counts as 1. A shorter pulse leaves the flag clear and has no other effect.
- R2: `int_src` bit order is: 0 test mode, 1 flash security, 2 security alarm, 3 temperature, 4 clock, 5 voltage, 6 monotonic-counter overflow, 7 time-counter overflow. A high bit sets the matching `src_flag` bit at the next edge. If that bit is enabled in `cfg_int_en`, the global flag sets at the same edge.
- R3: When `vbat_rst_n` is released, `por_flag` and `tamper_flag` are 1, `tamper_time` is 0, and the key-store and register-file sweeps start from word 0.
- R4: A `sw_force` strobe sets `tamper_flag` and sets no pin or source flag. It triggers the full response every time, even when the flag is already set.
- R5: On each response, `tamper_time` takes the value that `seconds` had at that edge.
- R6: A response starts the key sweep in the next cycle. It writes one word per cycle at addresses 0 to KEY_WORDS-1 in order. From that cycle until the sweep ends, `key_rdata` reads 0. After the sweep it follows `key_rdata_raw` again.
- R7: The register-file sweep (RF_WORDS words) starts on a response only when `cfg_wipe_rf` is 1.
- R8: The session sweep (SESS_WORDS words) starts on every response and again when `sys_rst_n` is released.
- R9: A `clr_we` strobe clears flags write-one-to-clear. `clr_mask` bits [NPINS-1:0] map to pins, [NPINS+7:NPINS] to internal sources, bit NPINS+8 to `por_flag` and bit NPINS+9 to `tamper_flag`. The global flag stays set while any enabled flag, or `por_flag`, remains set after the write.
- R10: `irq` equals `tamper_flag` when `cfg_irq_en` is 1, and `wake` equals `tamper_flag` when `cfg_wake_en` is 1. `chip_rst_req` is a one-cycle pulse in the cycle after a response, but only when `cfg_rst_en` is 1.
- R11: A source whose enable bit is 0 still sets its own flag but does not set `tamper_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Battery-domain clock |
| vbat_rst_n | input | 1 | Battery-domain power-on reset, active low |
| sys_rst_n | input | 1 | System reset, active low |
| tamper_pin | input | NPINS | External tamper pins, asynchronous |
| int_src | input | 8 | Internal alarm conditions |
| sw_force | input | 1 | Software force-tamper strobe |
| seconds | input | TW | Free-running seconds count |
| cfg_pin_en | input | NPINS | Pin flag enables |
| cfg_int_en | input | 8 | Internal flag enables |
| cfg_filt_len | input | FW | Glitch filter length in cycles |
| cfg_wipe_rf | input | 1 | Sweep the register file on tamper |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_rst_en | input | 1 | Chip-reset request enable |
| cfg_wake_en | input | 1 | Wakeup enable |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | NPINS+10 | Write-one-to-clear mask |
| pin_flag | output | NPINS | Pin flags |
| src_flag | output | 8 | Internal source flags |
| por_flag | output | 1 | Battery power-on flag |
| tamper_flag | output | 1 | Global tamper flag |
| tamper_time | output | TW | Captured tamper time |
| key_wipe_we | output | 1 | Key-store zero-write strobe |
| key_wipe_addr | output | clog2(KEY_WORDS) | Key-store sweep address |
| rf_wipe_we | output | 1 | Register-file zero-write strobe |
| rf_wipe_addr | output | clog2(RF_WORDS) | Register-file sweep address |
| sess_wipe_we | output | 1 | Session RAM zero-write strobe |
| sess_wipe_addr | output | clog2(SESS_WORDS) | Session RAM sweep address |
| wipe_done | output | 3 | Sweep-finished pulses {session, regfile, key} |
| key_rdata_raw | input | KW | Read data from the key store |
| key_rdata | output | KW | Key read data, zero while locked |
| irq | output | 1 | Tamper interrupt |
| wake | output | 1 | Wakeup output |
| chip_rst_req | output | 1 | Chip-reset request pulse |

## Verification
The hardest cases are the ones where a clear write and a live source meet in the same cycle, and a forced response that lands while the global flag is already set. These only show up after the power-on sweeps have finished and the reset flags have been cleared. The stimulus therefore runs the reset sweeps to completion first, clears the flags, and then creates each overlap on purpose: it clears only the global bit while a temperature flag is held, and it forces a second response while the flag is still set. A scoreboard queue holds the expected sweep addresses for each response. Any sweep write that nobody asked for, such as a register-file write while its enable is off, shows up as a write to an empty queue.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int NSRC = 8;
  localparam int SRC_TEST   = 0;
  localparam int SRC_FLASH  = 1;
  localparam int SRC_SECALM = 2;
  localparam int SRC_TEMP   = 3;
  localparam int SRC_CLOCK  = 4;
  localparam int SRC_VOLT   = 5;
  localparam int SRC_MONO   = 6;
  localparam int SRC_TIME   = 7;

  // Effective filter length: zero behaves like one.
  function automatic logic [7:0] tg_eff_len(input logic [7:0] len);
    return (len == 8'd0) ? 8'd1 : len;
  endfunction

  // Filter fires on the len-th consecutive synchronized high cycle.
  function automatic logic tg_filter_hit(input logic s, input logic [7:0] cnt,
                                         input logic [7:0] len);
    return s && (cnt >= (tg_eff_len(len) - 8'd1));
  endfunction
endpackage

// File: rtl/tg_pin_filter.sv
module tg_pin_filter #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic [FW-1:0] len,
  output logic          hit
);
  import tg_pkg::*;
  logic          s1_q, s2_q;
  logic [FW-1:0] cnt_q;

  assign hit = tg_filter_hit(s2_q, 8'(cnt_q), 8'(len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      if (!s2_q)     cnt_q <= '0;
      else if (!hit) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tg_wipe_chan.sv
module tg_wipe_chan #(
  parameter int   DEPTH    = 8,
  parameter logic RST_BUSY = 1'b1,
  localparam int  AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic          done,
  output logic          busy
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  logic          busy_q, done_q;
  logic [AW-1:0] addr_q;

  assign busy = busy_q;
  assign we   = busy_q;
  assign addr = addr_q;
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= RST_BUSY;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && (addr_q == LAST) && !start;
      if (start) begin
        busy_q <= 1'b1;
        addr_q <= '0;
      end else if (busy_q) begin
        if (addr_q == LAST) busy_q <= 1'b0;
        else                addr_q <= addr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tg_flags.sv
module tg_flags #(
  parameter int  NPINS = 8,
  parameter int  TW    = 32,
  localparam int NSRC  = tg_pkg::NSRC,
  localparam int NCLR  = NPINS + NSRC + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_hit,
  input  logic [NSRC-1:0]  int_src,
  input  logic             sw_force,
  input  logic [TW-1:0]    seconds,
  input  logic [NPINS-1:0] cfg_pin_en,
  input  logic [NSRC-1:0]  cfg_int_en,
  input  logic             clr_we,
  input  logic [NCLR-1:0]  clr_mask,
  output logic [NPINS-1:0] pin_flag,
  output logic [NSRC-1:0]  src_flag,
  output logic             por_flag,
  output logic             tamper_flag,
  output logic [TW-1:0]    tamper_time,
  output logic             fire
);
  localparam int POR_BIT  = NPINS + NSRC;
  localparam int GLOB_BIT = NPINS + NSRC + 1;

  logic [NCLR-1:0]  clr;
  logic [NPINS-1:0] pin_d;
  logic [NSRC-1:0]  src_d;
  logic             por_d, set_any, glob_d;

  always_comb begin
    clr     = clr_we ? clr_mask : '0;
    pin_d   = (pin_flag & ~clr[NPINS-1:0]) | pin_hit;
    src_d   = (src_flag & ~clr[NPINS +: NSRC]) | int_src;
    por_d   = por_flag & ~clr[POR_BIT];
    set_any = (|(pin_d & cfg_pin_en)) || (|(src_d & cfg_int_en)) || por_d;
    fire    = (set_any && !tamper_flag) || sw_force;
    glob_d  = set_any || sw_force || (tamper_flag && !clr[GLOB_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_flag    <= '0;
      src_flag    <= '0;
      por_flag    <= 1'b1;
      tamper_flag <= 1'b1;
      tamper_time <= '0;
    end else begin
      pin_flag    <= pin_d;
      src_flag    <= src_d;
      por_flag    <= por_d;
      tamper_flag <= glob_d;
      if (fire) tamper_time <= seconds;
    end
  end
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard #(
  parameter int  NPINS      = 8,
  parameter int  TW         = 32,
  parameter int  FW         = 8,
  parameter int  KW         = 32,
  parameter int  KEY_WORDS  = 8,
  parameter int  RF_WORDS   = 32,
  parameter int  SESS_WORDS = 512,
  localparam int NSRC       = tg_pkg::NSRC,
  localparam int NCLR       = NPINS + NSRC + 2,
  localparam int KAW        = $clog2(KEY_WORDS),
  localparam int RAW        = $clog2(RF_WORDS),
  localparam int SAW        = $clog2(SESS_WORDS)
) (
  input  logic             clk,
  input  logic             vbat_rst_n,
  input  logic             sys_rst_n,
  input  logic [NPINS-1:0] tamper_pin,
  input  logic [NSRC-1:0]  int_src,
  input  logic             sw_force,
  input  logic [TW-1:0]    seconds,
  input  logic [NPINS-1:0] cfg_pin_en,
  input  logic [NSRC-1:0]  cfg_int_en,
  input  logic [FW-1:0]    cfg_filt_len,
  input  logic             cfg_wipe_rf,
  input  logic             cfg_irq_en,
  input  logic             cfg_rst_en,
  input  logic             cfg_wake_en,
  input  logic             clr_we,
  input  logic [NCLR-1:0]  clr_mask,
  output logic [NPINS-1:0] pin_flag,
  output logic [NSRC-1:0]  src_flag,
  output logic             por_flag,
  output logic             tamper_flag,
  output logic [TW-1:0]    tamper_time,
  output logic             key_wipe_we,
  output logic [KAW-1:0]   key_wipe_addr,
  output logic             rf_wipe_we,
  output logic [RAW-1:0]   rf_wipe_addr,
  output logic             sess_wipe_we,
  output logic [SAW-1:0]   sess_wipe_addr,
  output logic [2:0]       wipe_done,
  input  logic [KW-1:0]    key_rdata_raw,
  output logic [KW-1:0]    key_rdata,
  output logic             irq,
  output logic             wake,
  output logic             chip_rst_req
);
  // Named internal events, visible to the bound checker.
  logic [NPINS-1:0] pin_hit;
  logic             resp_fire;
  logic             key_busy, rf_busy, sess_busy;
  logic             rst_req_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    tg_pin_filter #(.FW(FW)) u_filt (
      .clk  (clk),
      .rst_n(vbat_rst_n),
      .pin  (tamper_pin[g]),
      .len  (cfg_filt_len),
      .hit  (pin_hit[g])
    );
  end

  tg_flags #(.NPINS(NPINS), .TW(TW)) u_flags (
    .clk        (clk),
    .rst_n      (vbat_rst_n),
    .pin_hit    (pin_hit),
    .int_src    (int_src),
    .sw_force   (sw_force),
    .seconds    (seconds),
    .cfg_pin_en (cfg_pin_en),
    .cfg_int_en (cfg_int_en),
    .clr_we     (clr_we),
    .clr_mask   (clr_mask),
    .pin_flag   (pin_flag),
    .src_flag   (src_flag),
    .por_flag   (por_flag),
    .tamper_flag(tamper_flag),
    .tamper_time(tamper_time),
    .fire       (resp_fire)
  );

  tg_wipe_chan #(.DEPTH(KEY_WORDS), .RST_BUSY(1'b1)) u_key_wipe (
    .clk(clk), .rst_n(vbat_rst_n), .start(resp_fire),
    .we(key_wipe_we), .addr(key_wipe_addr), .done(wipe_done[0]), .busy(key_busy)
  );

  tg_wipe_chan #(.DEPTH(RF_WORDS), .RST_BUSY(1'b1)) u_rf_wipe (
    .clk(clk), .rst_n(vbat_rst_n), .start(resp_fire && cfg_wipe_rf),
    .we(rf_wipe_we), .addr(rf_wipe_addr), .done(wipe_done[1]), .busy(rf_busy)
  );

  tg_wipe_chan #(.DEPTH(SESS_WORDS), .RST_BUSY(1'b1)) u_sess_wipe (
    .clk(clk), .rst_n(sys_rst_n), .start(resp_fire),
    .we(sess_wipe_we), .addr(sess_wipe_addr), .done(wipe_done[2]), .busy(sess_busy)
  );

  always_ff @(posedge clk or negedge vbat_rst_n) begin
    if (!vbat_rst_n) rst_req_q <= 1'b0;
    else             rst_req_q <= resp_fire && cfg_rst_en;
  end

  assign key_rdata    = key_busy ? '0 : key_rdata_raw;
  assign irq          = tamper_flag && cfg_irq_en;
  assign wake         = tamper_flag && cfg_wake_en;
  assign chip_rst_req = rst_req_q;
endmodule

// File: rtl/tg_checks.sv
module tg_checks #(
  parameter int NPINS = 8, parameter int TW = 32, parameter int KW = 32,
  parameter int KAW = 3, parameter int SAW = 9, parameter int KEY_WORDS = 8
) (
  input logic             clk,
  input logic             vbat_rst_n,
  input logic             sys_rst_n,
  input logic             sw_force,
  input logic [TW-1:0]    seconds,
  input logic             tamper_flag,
  input logic [TW-1:0]    tamper_time,
  input logic [7:0]       src_flag,
  input logic [7:0]       cfg_int_en,
  input logic             clr_we,
  input logic [NPINS+9:0] clr_mask,
  input logic             key_wipe_we,
  input logic [KAW-1:0]   key_wipe_addr,
  input logic [KW-1:0]    key_rdata,
  input logic             rf_wipe_we,
  input logic             cfg_wipe_rf,
  input logic             sess_wipe_we,
  input logic [SAW-1:0]   sess_wipe_addr,
  input logic             chip_rst_req,
  input logic             cfg_rst_en,
  input logic             resp_fire
);
  logic [7:0] src_clr;
  assign src_clr = clr_we ? clr_mask[NPINS +: 8] : 8'h00;

  p_force_sets_flag_r4: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    sw_force |=> tamper_flag);
  p_time_capture_r5: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    resp_fire |=> tamper_time == $past(seconds));
  p_key_hidden_r6: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    sw_force |=> key_rdata == '0);
  p_key_step_r6: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    (key_wipe_we && key_wipe_addr != KAW'(KEY_WORDS - 1) && !resp_fire)
      |=> key_wipe_we && key_wipe_addr == $past(key_wipe_addr) + 1'b1);
  p_rf_gated_r7: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    (rf_wipe_we && !$past(rf_wipe_we)) |-> $past(cfg_wipe_rf));
  p_sess_start_r8: assert property (@(posedge clk) disable iff (!vbat_rst_n || !sys_rst_n)
    sw_force |=> sess_wipe_we && sess_wipe_addr == '0);
  p_src_holds_r9: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    (|(src_flag & cfg_int_en & ~src_clr)) |=> tamper_flag);
  p_rst_pulse_r10: assert property (@(posedge clk) disable iff (!vbat_rst_n)
    (sw_force && cfg_rst_en) |=> chip_rst_req);
endmodule

bind tamper_guard tg_checks #(
  .NPINS(NPINS), .TW(TW), .KW(KW), .KAW(KAW), .SAW(SAW), .KEY_WORDS(KEY_WORDS)
) u_tg_checks (
  .clk(clk), .vbat_rst_n(vbat_rst_n), .sys_rst_n(sys_rst_n), .sw_force(sw_force),
  .seconds(seconds), .tamper_flag(tamper_flag), .tamper_time(tamper_time),
  .src_flag(src_flag), .cfg_int_en(cfg_int_en), .clr_we(clr_we), .clr_mask(clr_mask),
  .key_wipe_we(key_wipe_we), .key_wipe_addr(key_wipe_addr), .key_rdata(key_rdata),
  .rf_wipe_we(rf_wipe_we), .cfg_wipe_rf(cfg_wipe_rf), .sess_wipe_we(sess_wipe_we),
  .sess_wipe_addr(sess_wipe_addr), .chip_rst_req(chip_rst_req), .cfg_rst_en(cfg_rst_en),
  .resp_fire(resp_fire)
);

// File: tb/tamper_guard_bench.sv
module tamper_guard_bench;
  localparam int NP = 8;
  localparam int POR_B = 16;
  localparam int GLB_B = 17;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic vbat_rst_n, sys_rst_n, sw_force, cfg_wipe_rf, cfg_irq_en, cfg_rst_en, cfg_wake_en, clr_we;
  logic [NP-1:0] tamper_pin, cfg_pin_en, pin_flag;
  logic [7:0] int_src, cfg_int_en, cfg_filt_len, src_flag;
  logic [31:0] seconds, tamper_time, key_rdata_raw, key_rdata;
  logic [NP+9:0] clr_mask;
  logic por_flag, tamper_flag, key_wipe_we, rf_wipe_we, sess_wipe_we, irq, wake, chip_rst_req;
  logic [2:0] key_wipe_addr, wipe_done;
  logic [4:0] rf_wipe_addr;
  logic [8:0] sess_wipe_addr;

  tamper_guard u_tamper_guard (
    .clk(clk), .vbat_rst_n(vbat_rst_n), .sys_rst_n(sys_rst_n), .tamper_pin(tamper_pin),
    .int_src(int_src), .sw_force(sw_force), .seconds(seconds), .cfg_pin_en(cfg_pin_en),
    .cfg_int_en(cfg_int_en), .cfg_filt_len(cfg_filt_len), .cfg_wipe_rf(cfg_wipe_rf),
    .cfg_irq_en(cfg_irq_en), .cfg_rst_en(cfg_rst_en), .cfg_wake_en(cfg_wake_en),
    .clr_we(clr_we), .clr_mask(clr_mask), .pin_flag(pin_flag), .src_flag(src_flag),
    .por_flag(por_flag), .tamper_flag(tamper_flag), .tamper_time(tamper_time),
    .key_wipe_we(key_wipe_we), .key_wipe_addr(key_wipe_addr), .rf_wipe_we(rf_wipe_we),
    .rf_wipe_addr(rf_wipe_addr), .sess_wipe_we(sess_wipe_we), .sess_wipe_addr(sess_wipe_addr),
    .wipe_done(wipe_done), .key_rdata_raw(key_rdata_raw), .key_rdata(key_rdata),
    .irq(irq), .wake(wake), .chip_rst_req(chip_rst_req)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  bit mon_en = 1'b0;
  int key_q[$];
  int rf_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected sweep addresses per response.
  task automatic expect_resp(input bit with_rf);
    for (int i = 0; i < 8; i++) key_q.push_back(i);
    if (with_rf) for (int i = 0; i < 32; i++) rf_q.push_back(i);
  endtask

  // Monitor: pops one expected address per observed zero-write.
  always @(negedge clk) begin
    if (mon_en && key_wipe_we) begin
      if (key_q.size() == 0) chk(1'b0, "R6 unexpected key write", key_wipe_addr, 0);
      else begin
        int e;
        e = key_q.pop_front();
        chk(key_wipe_addr == e[2:0], "R6 key sweep order", key_wipe_addr, e);
      end
    end
    if (mon_en && rf_wipe_we) begin
      if (rf_q.size() == 0) chk(1'b0, "R7 unexpected regfile write", rf_wipe_addr, 0);
      else begin
        int e;
        e = rf_q.pop_front();
        chk(rf_wipe_addr == e[4:0], "R7 regfile sweep order", rf_wipe_addr, e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear(input logic [NP+9:0] m);
    clr_mask = m; clr_we = 1'b1;
    cyc(1);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic force_once();
    sw_force = 1'b1;
    cyc(1);
    sw_force = 1'b0;
  endtask

  task automatic pin_pulse(input int p, input int n);
    tamper_pin[p] = 1'b1;
    cyc(n);
    tamper_pin[p] = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    vbat_rst_n = 1'b0; sys_rst_n = 1'b0; sw_force = 1'b0; clr_we = 1'b0; clr_mask = '0;
    tamper_pin = '0; int_src = '0; seconds = 32'd7; key_rdata_raw = 32'hA5A5_5A5A;
    cfg_pin_en = '1; cfg_int_en = '1; cfg_filt_len = 8'd4; cfg_wipe_rf = 1'b0;
    cfg_irq_en = 1'b1; cfg_rst_en = 1'b1; cfg_wake_en = 1'b0;
    cyc(5);
    vbat_rst_n = 1'b1; sys_rst_n = 1'b1;
    cyc(1);
    // R3 / R8: state after battery POR
    chk(por_flag == 1'b1, "R3 por_flag", por_flag, 1);
    chk(tamper_flag == 1'b1, "R3 tamper_flag", tamper_flag, 1);
    chk(tamper_time == 0, "R3 tamper_time", tamper_time, 0);
    chk(key_wipe_we && rf_wipe_we, "R3 sweeps running", {key_wipe_we, rf_wipe_we}, 3);
    chk(key_rdata == 0, "R6 key hidden on POR", key_rdata, 0);
    chk(sess_wipe_we == 1'b1, "R8 session sweep after reset", sess_wipe_we, 1);
    cyc(600);
    chk(!key_wipe_we && !rf_wipe_we && !sess_wipe_we, "R8 sweeps ended",
        {key_wipe_we, rf_wipe_we, sess_wipe_we}, 0);
    chk(key_rdata == key_rdata_raw, "R6 key visible", key_rdata, key_rdata_raw);
    chk(irq == 1'b1 && wake == 1'b0, "R10 irq/wake levels", {irq, wake}, 2);
    // R9: clear global alone is blocked by por_flag
    clear(18'(1) << GLB_B);
    chk(tamper_flag == 1'b1, "R9 global held by por", tamper_flag, 1);
    clear((18'(1) << GLB_B) | (18'(1) << POR_B));
    chk(!tamper_flag && !por_flag, "R9 both cleared", {tamper_flag, por_flag}, 0);
    chk(irq == 1'b0, "R10 irq low", irq, 0);

    mon_en = 1'b1;
    // R4 R5 R6 R7 R10: forced response
    seconds = 32'd100;
    expect_resp(1'b0);
    force_once();
    chk(tamper_flag == 1'b1, "R4 force sets flag", tamper_flag, 1);
    chk(pin_flag == 0 && src_flag == 0, "R4 no source flag", {pin_flag, src_flag}, 0);
    chk(tamper_time == 100, "R5 time captured", tamper_time, 100);
    chk(key_rdata == 0, "R6 key hidden", key_rdata, 0);
    chk(chip_rst_req == 1'b1, "R10 reset pulse", chip_rst_req, 1);
    chk(sess_wipe_we && sess_wipe_addr == 0, "R8 session restart", sess_wipe_addr, 0);
    cyc(1);
    chk(chip_rst_req == 1'b0, "R10 reset pulse one cycle", chip_rst_req, 0);
    cyc(12);
    chk(key_rdata == key_rdata_raw, "R6 key back", key_rdata, key_rdata_raw);
    // R4: force while already set still re-triggers
    seconds = 32'd150; cfg_rst_en = 1'b0;
    expect_resp(1'b0);
    force_once();
    chk(tamper_time == 150, "R4 recapture while set", tamper_time, 150);
    chk(chip_rst_req == 1'b0, "R10 reset disabled", chip_rst_req, 1'b0);
    cyc(12);
    clear(18'(1) << GLB_B);
    chk(tamper_flag == 1'b0, "R9 global cleared", tamper_flag, 0);

    // R2 R7 R9: temperature source with regfile sweep enabled
    cfg_wipe_rf = 1'b1; cfg_wake_en = 1'b1; seconds = 32'd200;
    expect_resp(1'b1);
    int_src[3] = 1'b1;
    cyc(1);
    chk(src_flag == 8'h08, "R2 temperature flag", src_flag, 8'h08);
    chk(tamper_flag == 1'b1, "R2 global set", tamper_flag, 1);
    chk(tamper_time == 200, "R5 time on source", tamper_time, 200);
    chk(wake == 1'b1, "R10 wake", wake, 1);
    clear(18'(1) << GLB_B);
    chk(tamper_flag == 1'b1, "R9 clear blocked by live source", tamper_flag, 1);
    int_src[3] = 1'b0;
    clear((18'(1) << GLB_B) | (18'(1) << (NP + 3)));
    chk(!tamper_flag && src_flag == 0, "R9 clear source and global", {tamper_flag, src_flag}, 0);
    cyc(40);

    // R11: disabled voltage source
    cfg_int_en[5] = 1'b0;
    int_src[5] = 1'b1;
    cyc(1);
    int_src[5] = 1'b0;
    cyc(3);
    chk(src_flag == 8'h20, "R11 own flag set", src_flag, 8'h20);
    chk(tamper_flag == 1'b0, "R11 global untouched", tamper_flag, 0);
    clear(18'(1) << (NP + 5));
    cfg_int_en[5] = 1'b1;
    chk(src_flag == 0, "R9 source cleared", src_flag, 0);

    // R1: glitch filter, length 4
    pin_pulse(2, 3);
    cyc(10);
    chk(pin_flag == 0 && tamper_flag == 0, "R1 short pulse rejected", pin_flag, 0);
    seconds = 32'd300;
    expect_resp(1'b1);
    pin_pulse(2, 4);
    cyc(6);
    chk(pin_flag == 8'h04, "R1 long pulse flagged", pin_flag, 8'h04);
    chk(tamper_flag && tamper_time == 300, "R1 global and time", tamper_time, 300);
    cyc(40);
    clear((18'(1) << GLB_B) | 18'h4);
    chk(!tamper_flag && pin_flag == 0, "R9 pin cleared", pin_flag, 0);

    // R1: length 0 acts as 1
    cfg_filt_len = 8'd0;
    expect_resp(1'b1);
    pin_pulse(0, 1);
    cyc(4);
    chk(pin_flag == 8'h01, "R1 zero length acts as one", pin_flag, 8'h01);
    cyc(40);
    chk(key_q.size() == 0, "R6 all key writes seen", key_q.size(), 0);
    chk(rf_q.size() == 0, "R7 all regfile writes seen", rf_q.size(), 0);
    summary();
  end
endmodule